// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Front End

This block sits at the entry of a single-precision fused multiply-add unit that forms z + x*y. It inspects the three 32-bit operands, sorts each into one of six classes (zero, subnormal, normal, infinity, quiet NaN, signalling NaN), and decides whether the final answer can be produced without any mantissa arithmetic. When it can, the block presents a bypass result together with an invalid-operation flag. When it cannot, it raises a proceed signal and hands the arithmetic datapath the sign, significand and unbiased exponent of every operand. Each significand already carries its hidden bit.

A mode input selects how subnormal operands are treated. In flush mode they act as zeros that keep their sign. In normalise mode their fraction is shifted left until the hidden bit position is set, and the exponent is lowered by the same amount. The decision logic follows a fixed priority: NaN handling first, then the product's class, then the addend's class. Because of this order, an infinite addend has no effect once the product is already infinite.

An optional output register stage is chosen by parameter. With the default of one stage, results appear one clock after the operands are accepted.

Top module: `fma_special_front`

## Requirements
- R1: A signalling-NaN addend z has the highest priority. The bypass result is z with fraction bit 22 set (sign and remaining payload kept), and invalid_op is raised.
- R2: A signalling NaN in y is returned quieted when x is not a signalling NaN. Otherwise a signalling NaN in x is returned quieted. Both cases raise invalid_op. Quieting sets fraction bit 22.
- R3: With no signalling NaN present, a quiet-NaN y is returned unchanged when x is not a NaN. Otherwise a quiet-NaN x is returned unchanged. A quiet-NaN addend loses to either of these, and invalid_op stays low.
- R4: Infinity times zero, in either order, returns the default NaN 0x7FC00000 with invalid_op raised. If the addend is a quiet NaN, the addend is returned unchanged instead and no flag is raised.
- R5: Infinity times a nonzero non-NaN value, or infinity times infinity, returns infinity with sign xs XOR ys. An infinite addend is ignored here, but a quiet-NaN addend is returned unchanged.
- R6: A zero product, with neither multiplicand NaN nor infinite, returns the addend. For an infinite addend this is an infinity carrying the addend's sign.
- R7: A finite nonzero product returns the addend when the addend is a quiet NaN or an infinity. Otherwise proceed is raised and bypass_vld is low.
- R8: With flush_sub=1, every subnormal operand is treated as a zero of its own sign. A flushed addend that is returned comes back as that signed zero.
- R9: With flush_sub=0, a subnormal operand counts as finite and nonzero. Its significand output has bit 23 set, and its exponent is -126 minus the number of left shifts applied.
- R10: A normal operand is output as significand {1, fraction}, exponent field minus 127, and its sign bit.
- R11: Results appear exactly one clock after in_valid. out_valid follows in_valid with that delay, and reset clears out_valid, bypass_vld, proceed and invalid_op.
- R12: While out_valid is high, exactly one of bypass_vld and proceed is high, and invalid_op is high only together with bypass_vld. While out_valid is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| flush_sub | input | 1 | 1: subnormals act as signed zero; 0: subnormals are normalised |
| op_x | input | 32 | Multiplicand x |
| op_y | input | 32 | Multiplicand y |
| op_z | input | 32 | Addend z |
| out_valid | output | 1 | Result fields valid |
| bypass_vld | output | 1 | Final result available without arithmetic |
| bypass_res | output | 32 | Bypass result, zero when not bypassing |
| invalid_op | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Arithmetic datapath must compute the result |
| x_sign | output | 1 | Sign of x |
| x_sig | output | 24 | Significand of x with hidden bit |
| x_exp | output | 10 | Unbiased signed exponent of x |
| y_sign | output | 1 | Sign of y |
| y_sig | output | 24 | Significand of y with hidden bit |
| y_exp | output | 10 | Unbiased signed exponent of y |
| z_sign | output | 1 | Sign of z |
| z_sig | output | 24 | Significand of z with hidden bit |
| z_exp | output | 10 | Unbiased signed exponent of z |

## Verification
Some properties are checked by assertions on every cycle. These are: the one-cycle timing of out_valid, the rule that exactly one of bypass and proceed is active, the rule that invalid_op appears only with a bypass, and the rule that a flagged result is a NaN. They also check that every NaN leaving the bypass port is quiet, and that both multiplicand significands carry a set hidden bit whenever proceed is raised. Other behaviour can only be shown by the bench's directed scenarios, since it depends on particular operand patterns. This includes which NaN wins under each combination of classes, the default-NaN encoding and its quiet-addend exception, the ignored infinite addend when the product is infinite, the signed-zero return of a flushed addend, and the exact shift counts and exponents produced for subnormals.

// File: rtl/fma_sp_pkg.sv
`timescale 1ns/1ps
package fma_sp_pkg;

   // Operand classes seen by the special-case resolver
   typedef enum logic [2:0] {
      CL_ZERO = 3'd0,
      CL_SUB  = 3'd1,
      CL_NORM = 3'd2,
      CL_INF  = 3'd3,
      CL_QNAN = 3'd4,
      CL_SNAN = 3'd5
   } op_class_e;

endpackage

// File: rtl/fma_subnorm_norm.sv
`timescale 1ns/1ps
// Shifts a nonzero subnormal fraction up until the hidden-bit slot is set
// and lowers the exponent by the same count.
module fma_subnorm_norm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W-1:0]       frac,
   output logic [FRAC_W:0]         sig,
   output logic signed [EXP_W+1:0] sexp
);
   localparam int SEXP_W = EXP_W + 2;
   localparam int LZ_W   = $clog2(FRAC_W + 1);
   localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
   localparam logic [SEXP_W-1:0] MIN_E = SEXP_W'(1 - BIAS);

   logic [LZ_W-1:0]   lz;
   logic [SEXP_W-1:0] e_raw;

   // Highest set bit wins: scan upward, later hits overwrite earlier ones
   always_comb begin
      lz = '0;
      for (int i = 0; i < FRAC_W; i++) begin
         if (frac[i]) lz = LZ_W'(FRAC_W - i);
      end
   end

   always_comb begin
      sig   = {1'b0, frac} << lz;
      e_raw = MIN_E - SEXP_W'(lz);
      sexp  = $signed(e_raw);
   end

endmodule

// File: rtl/fma_op_classifier.sv
`timescale 1ns/1ps
module fma_op_classifier
   import fma_sp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]   opnd,
   input  logic                    flush_sub,
   output op_class_e               cls,
   output logic                    sgn,
   output logic [EXP_W+FRAC_W:0]   quieted,
   output logic [EXP_W+FRAC_W:0]   eff,
   output logic [FRAC_W:0]         sig,
   output logic signed [EXP_W+1:0] sexp
);
   localparam int W      = 1 + EXP_W + FRAC_W;
   localparam int SEXP_W = EXP_W + 2;
   localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
   localparam logic [SEXP_W-1:0] BIAS_V = SEXP_W'(BIAS);
   localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

   logic [EXP_W-1:0]  efld;
   logic [FRAC_W-1:0] ffld;
   logic              e_ones, e_zero, f_nz;
   logic [FRAC_W:0]   sub_sig;
   logic signed [SEXP_W-1:0] sub_exp;
   logic [SEXP_W-1:0] norm_e;

   assign efld   = opnd[FRAC_W +: EXP_W];
   assign ffld   = opnd[FRAC_W-1:0];
   assign sgn    = opnd[W-1];
   assign e_ones = &efld;
   assign e_zero = ~|efld;
   assign f_nz   = |ffld;

   fma_subnorm_norm #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_norm (
      .frac (ffld),
      .sig  (sub_sig),
      .sexp (sub_exp)
   );

   always_comb begin
      if (e_ones) begin
         if (!f_nz)                cls = CL_INF;
         else if (ffld[FRAC_W-1])  cls = CL_QNAN;
         else                      cls = CL_SNAN;
      end else if (e_zero) begin
         if (f_nz && !flush_sub)   cls = CL_SUB;
         else                      cls = CL_ZERO;
      end else begin
         cls = CL_NORM;
      end
   end

   assign quieted = opnd | QBIT;
   assign eff     = (e_zero && f_nz && flush_sub) ? {sgn, {(W-1){1'b0}}} : opnd;

   assign norm_e = SEXP_W'(efld) - BIAS_V;

   always_comb begin
      unique case (cls)
         CL_NORM: begin
            sig  = {1'b1, ffld};
            sexp = $signed(norm_e);
         end
         CL_SUB: begin
            sig  = sub_sig;
            sexp = sub_exp;
         end
         default: begin
            sig  = '0;
            sexp = '0;
         end
      endcase
   end

endmodule

// File: rtl/fma_special_resolver.sv
`timescale 1ns/1ps
// Fixed-priority decision: NaNs, then product class, then addend class.
module fma_special_resolver
   import fma_sp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  op_class_e             cls_x,
   input  op_class_e             cls_y,
   input  op_class_e             cls_z,
   input  logic                  sx,
   input  logic                  sy,
   input  logic                  sz,
   input  logic [EXP_W+FRAC_W:0] qx,
   input  logic [EXP_W+FRAC_W:0] qy,
   input  logic [EXP_W+FRAC_W:0] qz,
   input  logic [EXP_W+FRAC_W:0] ex,
   input  logic [EXP_W+FRAC_W:0] ey,
   input  logic [EXP_W+FRAC_W:0] ez,
   output logic                  byp,
   output logic                  inv,
   output logic [EXP_W+FRAC_W:0] res
);
   localparam int W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   function automatic logic [W-1:0] signed_inf(input logic s);
      return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   endfunction

   logic x_zero, y_zero, x_inf, y_inf, z_qnan, z_inf;

   assign x_zero = (cls_x == CL_ZERO);
   assign y_zero = (cls_y == CL_ZERO);
   assign x_inf  = (cls_x == CL_INF);
   assign y_inf  = (cls_y == CL_INF);
   assign z_qnan = (cls_z == CL_QNAN);
   assign z_inf  = (cls_z == CL_INF);

   always_comb begin
      byp = 1'b1;
      inv = 1'b0;
      res = ez;
      if (cls_z == CL_SNAN) begin
         inv = 1'b1;
         res = qz;
      end else if (cls_y == CL_SNAN && cls_x != CL_SNAN) begin
         inv = 1'b1;
         res = qy;
      end else if (cls_x == CL_SNAN) begin
         inv = 1'b1;
         res = qx;
      end else if (cls_y == CL_QNAN && cls_x != CL_QNAN) begin
         res = ey;
      end else if (cls_x == CL_QNAN) begin
         res = ex;
      end else if ((x_inf && y_zero) || (x_zero && y_inf)) begin
         if (!z_qnan) begin
            inv = 1'b1;
            res = DEF_NAN;
         end
      end else if (x_inf || y_inf) begin
         if (!z_qnan) res = signed_inf(sx ^ sy);
      end else if (x_zero || y_zero) begin
         if (z_inf) res = signed_inf(sz);
      end else if (z_inf) begin
         res = signed_inf(sz);
      end else if (!z_qnan) begin
         byp = 1'b0;
         res = '0;
      end
   end

endmodule

// File: rtl/fma_special_front.sv
`timescale 1ns/1ps
module fma_special_front
   import fma_sp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter int OUT_STAGE = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    flush_sub,
   input  logic [EXP_W+FRAC_W:0]   op_x,
   input  logic [EXP_W+FRAC_W:0]   op_y,
   input  logic [EXP_W+FRAC_W:0]   op_z,
   output logic                    out_valid,
   output logic                    bypass_vld,
   output logic [EXP_W+FRAC_W:0]   bypass_res,
   output logic                    invalid_op,
   output logic                    proceed,
   output logic                    x_sign,
   output logic [FRAC_W:0]         x_sig,
   output logic signed [EXP_W+1:0] x_exp,
   output logic                    y_sign,
   output logic [FRAC_W:0]         y_sig,
   output logic signed [EXP_W+1:0] y_exp,
   output logic                    z_sign,
   output logic [FRAC_W:0]         z_sig,
   output logic signed [EXP_W+1:0] z_exp
);
   localparam int W      = 1 + EXP_W + FRAC_W;
   localparam int SEXP_W = EXP_W + 2;
   localparam int N_OPS  = 3;
   localparam int IX     = 0;
   localparam int IY     = 1;
   localparam int IZ     = 2;

   // Elaboration-time parameter checks
   if (EXP_W < 3) begin : g_bad_exp
      $error("fma_special_front: EXP_W must be at least 3");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fma_special_front: FRAC_W must be at least 2");
   end
   if (FRAC_W >= 2 ** (EXP_W - 1)) begin : g_bad_range
      $error("fma_special_front: FRAC_W too wide for exponent range");
   end
   if (!(OUT_STAGE inside {0, 1})) begin : g_bad_stage
      $error("fma_special_front: OUT_STAGE must be 0 or 1");
   end

   logic [W-1:0]             opnd    [N_OPS];
   op_class_e                cls     [N_OPS];
   logic                     sgn     [N_OPS];
   logic [W-1:0]             quiet   [N_OPS];
   logic [W-1:0]             eff     [N_OPS];
   logic [FRAC_W:0]          sig     [N_OPS];
   logic signed [SEXP_W-1:0] sexp    [N_OPS];

   assign opnd[IX] = op_x;
   assign opnd[IY] = op_y;
   assign opnd[IZ] = op_z;

   for (genvar k = 0; k < N_OPS; k++) begin : g_cls
      fma_op_classifier #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_cls (
         .opnd      (opnd[k]),
         .flush_sub (flush_sub),
         .cls       (cls[k]),
         .sgn       (sgn[k]),
         .quieted   (quiet[k]),
         .eff       (eff[k]),
         .sig       (sig[k]),
         .sexp      (sexp[k])
      );
   end

   logic         r_byp, r_inv;
   logic [W-1:0] r_res;

   fma_special_resolver #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_res (
      .cls_x (cls[IX]),
      .cls_y (cls[IY]),
      .cls_z (cls[IZ]),
      .sx    (sgn[IX]),
      .sy    (sgn[IY]),
      .sz    (sgn[IZ]),
      .qx    (quiet[IX]),
      .qy    (quiet[IY]),
      .qz    (quiet[IZ]),
      .ex    (eff[IX]),
      .ey    (eff[IY]),
      .ez    (eff[IZ]),
      .byp   (r_byp),
      .inv   (r_inv),
      .res   (r_res)
   );

   logic         c_byp, c_inv, c_prc;
   logic [W-1:0] c_res;

   assign c_byp = in_valid & r_byp;
   assign c_inv = in_valid & r_inv;
   assign c_prc = in_valid & ~r_byp;
   assign c_res = c_byp ? r_res : '0;

   if (OUT_STAGE == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            bypass_vld <= 1'b0;
            invalid_op <= 1'b0;
            proceed    <= 1'b0;
            bypass_res <= '0;
            x_sign     <= 1'b0;
            x_sig      <= '0;
            x_exp      <= '0;
            y_sign     <= 1'b0;
            y_sig      <= '0;
            y_exp      <= '0;
            z_sign     <= 1'b0;
            z_sig      <= '0;
            z_exp      <= '0;
         end else begin
            out_valid  <= in_valid;
            bypass_vld <= c_byp;
            invalid_op <= c_inv;
            proceed    <= c_prc;
            bypass_res <= c_res;
            x_sign     <= sgn[IX];
            x_sig      <= sig[IX];
            x_exp      <= sexp[IX];
            y_sign     <= sgn[IY];
            y_sig      <= sig[IY];
            y_exp      <= sexp[IY];
            z_sign     <= sgn[IZ];
            z_sig      <= sig[IZ];
            z_exp      <= sexp[IZ];
         end
      end
   end else begin : g_comb
      assign out_valid  = in_valid;
      assign bypass_vld = c_byp;
      assign invalid_op = c_inv;
      assign proceed    = c_prc;
      assign bypass_res = c_res;
      assign x_sign     = sgn[IX];
      assign x_sig      = sig[IX];
      assign x_exp      = sexp[IX];
      assign y_sign     = sgn[IY];
      assign y_sig      = sig[IY];
      assign y_exp      = sexp[IY];
      assign z_sign     = sgn[IZ];
      assign z_sig      = sig[IZ];
      assign z_exp      = sexp[IZ];
   end

endmodule

// File: rtl/fma_special_front_chk.sv
`timescale 1ns/1ps
module fma_special_front_chk #(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter int OUT_STAGE = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  out_valid,
   input logic                  bypass_vld,
   input logic [EXP_W+FRAC_W:0] bypass_res,
   input logic                  invalid_op,
   input logic                  proceed,
   input logic                  x_top,
   input logic                  y_top
);
   logic res_is_nan;
   assign res_is_nan = (&bypass_res[FRAC_W +: EXP_W]) && (|bypass_res[FRAC_W-1:0]);

   if (OUT_STAGE == 1) begin : g_lat
      // R11
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R11
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end

   // R12
   one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({bypass_vld, proceed}) == 1);
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(bypass_vld || proceed || invalid_op));
   // R12
   inv_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_op |-> bypass_vld);
   // R4
   inv_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_op |-> res_is_nan);
   // R2
   nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_vld && res_is_nan) |-> bypass_res[FRAC_W-1]);
   // R9
   norm_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proceed |-> (x_top && y_top));

endmodule

bind fma_special_front fma_special_front_chk #(
   .EXP_W     (EXP_W),
   .FRAC_W    (FRAC_W),
   .OUT_STAGE (OUT_STAGE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .bypass_vld (bypass_vld),
   .bypass_res (bypass_res),
   .invalid_op (invalid_op),
   .proceed    (proceed),
   .x_top      (x_sig[FRAC_W]),
   .y_top      (y_sig[FRAC_W])
);

// File: tb/fma_special_front_tb.sv
`timescale 1ns/1ps
module fma_special_front_tb;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               flush_sub = 1'b0;
   logic [31:0]        op_x = '0, op_y = '0, op_z = '0;
   logic               out_valid, bypass_vld, invalid_op, proceed;
   logic [31:0]        bypass_res;
   logic               x_sign, y_sign, z_sign;
   logic [23:0]        x_sig, y_sig, z_sig;
   logic signed [9:0]  x_exp, y_exp, z_exp;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fma_special_front u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flush_sub(flush_sub),
      .op_x(op_x), .op_y(op_y), .op_z(op_z),
      .out_valid(out_valid), .bypass_vld(bypass_vld), .bypass_res(bypass_res),
      .invalid_op(invalid_op), .proceed(proceed),
      .x_sign(x_sign), .x_sig(x_sig), .x_exp(x_exp),
      .y_sign(y_sign), .y_sig(y_sig), .y_exp(y_exp),
      .z_sign(z_sign), .z_sig(z_sig), .z_exp(z_exp)
   );

   typedef struct {
      string       tag;
      logic        byp;
      logic        inv;
      logic [31:0] res;
      logic [2:0]  s;
      logic [23:0] sg [3];
      int          ex [3];
   } item_t;

   item_t sb[$];

   // class codes: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan
   function automatic int kind(input logic [31:0] v, input logic fl);
      if (v[30:23] == 8'hFF)
         return (v[22:0] == 0) ? 3 : (v[22] ? 4 : 5);
      if (v[30:23] == 8'h00)
         return (v[22:0] == 0 || fl) ? 0 : 1;
      return 2;
   endfunction

   function automatic void parts(input logic [31:0] v, input logic fl,
                                 output logic [23:0] m, output int e);
      int k;
      k = kind(v, fl);
      m = '0;
      e = 0;
      if (k == 2) begin
         m = {1'b1, v[22:0]};
         e = int'(v[30:23]) - 127;
      end else if (k == 1) begin
         m = {1'b0, v[22:0]};
         e = -126;
         while (!m[23]) begin
            m = m << 1;
            e = e - 1;
         end
      end
   endfunction

   task automatic fail(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
   endtask

   task automatic send(input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] z, input logic fl, input string tag);
      item_t it;
      int kx, ky, kz;
      logic [31:0] zv;
      kx = kind(x, fl);
      ky = kind(y, fl);
      kz = kind(z, fl);
      zv = (z[30:23] == 0 && z[22:0] != 0 && fl) ? {z[31], 31'd0} : z;
      it.tag = tag;
      it.byp = 1'b1;
      it.inv = 1'b0;
      it.res = zv;
      if (kz == 5) begin
         it.inv = 1'b1; it.res = z | 32'h0040_0000;
      end else if (ky == 5 && kx != 5) begin
         it.inv = 1'b1; it.res = y | 32'h0040_0000;
      end else if (kx == 5) begin
         it.inv = 1'b1; it.res = x | 32'h0040_0000;
      end else if (ky == 4 && kx != 4) begin
         it.res = y;
      end else if (kx == 4) begin
         it.res = x;
      end else if ((kx == 3 && ky == 0) || (kx == 0 && ky == 3)) begin
         if (kz != 4) begin
            it.inv = 1'b1; it.res = 32'h7FC0_0000;
         end
      end else if (kx == 3 || ky == 3) begin
         if (kz != 4) it.res = {x[31] ^ y[31], 8'hFF, 23'd0};
      end else if (kx == 0 || ky == 0) begin
         it.res = zv;
      end else if (kz == 3 || kz == 4) begin
         it.res = z;
      end else begin
         it.byp = 1'b0;
         it.res = '0;
      end
      it.s = {z[31], y[31], x[31]};
      parts(x, fl, it.sg[0], it.ex[0]);
      parts(y, fl, it.sg[1], it.ex[1]);
      parts(z, fl, it.sg[2], it.ex[2]);
      @(negedge clk);
      op_x = x; op_y = y; op_z = z; flush_sub = fl; in_valid = 1'b1;
      sb.push_back(it);
   endtask

   // Scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
               fail("R11", "unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
               item_t it;
               logic bad;
               it = sb.pop_front();
               bad = 1'b0;
               if (bypass_vld !== it.byp) begin
                  fail(it.tag, "bypass_vld", 32'(bypass_vld), 32'(it.byp)); bad = 1'b1;
               end
               if (!bad && invalid_op !== it.inv) begin
                  fail(it.tag, "invalid_op", 32'(invalid_op), 32'(it.inv)); bad = 1'b1;
               end
               if (!bad && it.byp && bypass_res !== it.res) begin
                  fail(it.tag, "bypass_res", bypass_res, it.res); bad = 1'b1;
               end
               if (!bad && !it.byp) begin
                  if ({z_sign, y_sign, x_sign} !== it.s) begin
                     fail(it.tag, "signs", 32'({z_sign, y_sign, x_sign}), 32'(it.s)); bad = 1'b1;
                  end else if (x_sig !== it.sg[0] || int'(x_exp) != it.ex[0]) begin
                     fail(it.tag, "x sig/exp", {x_sig, 8'(x_exp)}, {it.sg[0], 8'(it.ex[0])}); bad = 1'b1;
                  end else if (y_sig !== it.sg[1] || int'(y_exp) != it.ex[1]) begin
                     fail(it.tag, "y sig/exp", {y_sig, 8'(y_exp)}, {it.sg[1], 8'(it.ex[1])}); bad = 1'b1;
                  end else if (z_sig !== it.sg[2] || int'(z_exp) != it.ex[2]) begin
                     fail(it.tag, "z sig/exp", {z_sig, 8'(z_exp)}, {it.sg[2], 8'(it.ex[2])}); bad = 1'b1;
                  end
               end
               // R12 path exclusivity on every result
               checks++;
               if ((bypass_vld == proceed) || (invalid_op && !bypass_vld))
                  fail("R12", "path flags", 32'({bypass_vld, proceed, invalid_op}), 32'({it.byp, !it.byp, it.inv}));
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid || bypass_vld || proceed || invalid_op)
         fail("R11", "reset state", 32'({out_valid, bypass_vld, proceed, invalid_op}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      send(32'h3F800000, 32'hFF800010, 32'h7F800005, 1'b0, "R1");
      send(32'h7FC00001, 32'hFF800010, 32'h3F800000, 1'b0, "R2");
      send(32'h7F800005, 32'hFF800010, 32'h3F800000, 1'b0, "R2");
      send(32'h7F800005, 32'h40000000, 32'h7FC00001, 1'b0, "R2");
      send(32'h3F800000, 32'h7FC00123, 32'h7FC00001, 1'b0, "R3");
      send(32'h7FC00001, 32'hFFC00002, 32'h3F800000, 1'b0, "R3");
      send(32'h7FC00001, 32'h7F800000, 32'h7FC00777, 1'b0, "R3");
      send(32'h7F800000, 32'h00000000, 32'h3F800000, 1'b0, "R4");
      send(32'h80000000, 32'hFF800000, 32'h7FC00777, 1'b0, "R4");
      send(32'h7F800000, 32'hBFC00000, 32'h7F800000, 1'b0, "R5");
      send(32'hFF800000, 32'hFF800000, 32'h3F800000, 1'b0, "R5");
      send(32'h7F800000, 32'h40000000, 32'h7FC00777, 1'b0, "R5");
      send(32'h00000000, 32'h40000000, 32'hBFC00000, 1'b0, "R6");
      send(32'h80000000, 32'h3F800000, 32'hFF800000, 1'b0, "R6");
      send(32'h00000000, 32'h00000000, 32'h7FC00777, 1'b0, "R6");
      send(32'h3F800000, 32'h40000000, 32'h7FC00777, 1'b0, "R7");
      send(32'h3F800000, 32'h40000000, 32'hFF800000, 1'b0, "R7");
      send(32'h3F800000, 32'h40000000, 32'h40000000, 1'b0, "R7");
      send(32'h00400000, 32'h40000000, 32'hBFC00000, 1'b1, "R8");
      send(32'h3F800000, 32'h00000000, 32'h80200000, 1'b1, "R8");
      send(32'h7F800000, 32'h00000001, 32'h3F800000, 1'b1, "R8");
      send(32'h00400000, 32'h40000000, 32'hBFC00000, 1'b0, "R9");
      send(32'h3F800000, 32'h00000000, 32'h80200000, 1'b0, "R9");
      send(32'h7F800000, 32'h00000001, 32'h3F800000, 1'b0, "R9");
      send(32'h00000001, 32'h80200000, 32'h00400000, 1'b0, "R9");
      send(32'hBFC00000, 32'h40000000, 32'h3F800000, 1'b0, "R10");
      send(32'h4B7FFFFF, 32'h00800000, 32'hC2F60000, 1'b0, "R10");

      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      checks++;
      if (sb.size() != 0)
         fail("R11", "results outstanding", 32'(sb.size()), 32'd0);
      checks++;
      if (out_valid || bypass_vld || proceed)
         fail("R11", "idle after drain", 32'({out_valid, bypass_vld, proceed}), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule